// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This core executes a tiny instruction set in which no instruction names a register. Operands live on an internal last-in first-out stack: a memory load instruction moves a word from memory onto the stack, a memory store instruction moves the top word back out to memory, and each arithmetic instruction takes the two uppermost words and replaces them with one result. Instructions and data share one synchronous single-port memory. A read returns its word one clock after the address is presented.

Each instruction runs through a small multicycle sequence: fetch, decode, an optional memory step and an optional execute step. The core stops in a halted state when it meets the halt instruction. It also stops, and raises a fault flag, when an instruction would overfill or underrun the stack or when the opcode is not defined. A host loads a program into memory while reset is held, releases reset, and waits for `halted`.

Top module: `stk_core`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, the core presents address 0 for instruction fetch with `memWe` low, and both `halted` and `fault` are low; the stack is empty.
- R2: An instruction word carries its opcode in bits [15:12] and a memory address in bits [11:0]; the opcodes are 0 load-to-stack, 1 store-from-stack, 2 add, 3 subtract, 4 multiply, 15 halt.
- R3: Opcode 0 reads the word at its address and places it on top of the stack. Opcode 1 writes the top word to its address and removes it from the stack. Words come back out in reverse order of entry.
- R4: Add replaces the two upper words with their sum modulo 2^16.
- R5: Subtract pushes the earlier-pushed word minus the top word, so load A, load B, subtract leaves A-B in place of both.
- R6: Multiply pushes the low 16 bits of the product of the two upper words.
- R7: The stack holds 8 words. A load with 8 words already present halts the core with `fault` high and writes no memory.
- R8: A store with the stack empty halts the core with `fault` high and writes no memory.
- R9: An arithmetic opcode with fewer than two words on the stack halts the core with `fault` high; no later instruction runs.
- R10: The halt opcode stops the core with `fault` low; no instruction after it runs and memory is not written afterwards; `halted` stays high until reset.
- R11: Any opcode from 5 to 14 halts the core with `fault` high.
- R12: Load takes 4 cycles, store and arithmetic take 3 cycles each, and halt reaches the halted state 2 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| memAddr | output | 12 | Memory address for instruction fetch or data access |
| memWe | output | 1 | Memory write strobe for the current cycle |
| memWdata | output | 16 | Data written to memory when `memWe` is high |
| memRdata | input | 16 | Memory read data, valid one cycle after the address |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Core stopped on a stack or opcode error |

## Verification
The hardest situation to reach is the exact stack boundary. The eighth load must be accepted and the ninth refused, and the stack contents at full depth are visible only through later stores. The bench fills the stack to its depth and drains it into eight separate locations, which checks both acceptance and reverse ordering. A separate program issues nine loads and then a store to a sentinel location; the sentinel must stay unchanged and the cycle count must end exactly at the refused ninth load. The arithmetic is swept over every pair from a set of edge-case words for all three operations.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LOAD  = 4'd0;
  localparam logic [OP_W-1:0] OP_STORE = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB   = 4'd3;
  localparam logic [OP_W-1:0] OP_MUL   = 4'd4;
  localparam logic [OP_W-1:0] OP_HALT  = 4'd15;

  typedef enum logic [2:0] {
    S_FETCH,
    S_DECODE,
    S_MEM,
    S_EXEC,
    S_HALT
  } state_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_MUL
  } alu_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fetch;      // drive PC on the bus, advance PC
    logic latchIr;    // capture returned instruction word
    logic dataWrite;  // write top of stack to memory
    logic pushMem;    // push returned memory word
    logic popOne;     // drop top of stack
    logic binop;      // combine two upper words into one
    alu_e aluSel;
  } ctrl_t;

endpackage

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrl_t                ctl,
  input  logic [DATA_W-1:0]    memRdata,
  output logic [DATA_W-OP_W-1:0] memAddr,
  output logic [DATA_W-1:0]    memWdata,
  output logic [OP_W-1:0]      irOp,
  output logic                 spFull,
  output logic                 spEmpty,
  output logic                 spLow
);

  localparam int ADDR_W = DATA_W - OP_W;
  localparam int SP_W   = $clog2(DEPTH + 1);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] stk [DEPTH];
  logic [SP_W-1:0]   sp;

  logic [IDX_W-1:0]  tosIdx, nosIdx, pushIdx;
  logic [DATA_W-1:0] tos, nos, aluOut;

  assign pushIdx = IDX_W'(sp);
  assign tosIdx  = IDX_W'(sp - SP_W'(1));
  assign nosIdx  = IDX_W'(sp - SP_W'(2));
  assign tos     = stk[tosIdx];
  assign nos     = stk[nosIdx];

  assign spFull  = (sp == SP_W'(DEPTH));
  assign spEmpty = (sp == '0);
  assign spLow   = (sp < SP_W'(2));

  assign irOp     = ir[DATA_W-1 -: OP_W];
  assign memAddr  = ctl.fetch ? pc : ir[ADDR_W-1:0];
  assign memWdata = tos;

  always_comb begin
    unique case (ctl.aluSel)
      ALU_SUB: aluOut = nos - tos;
      ALU_MUL: aluOut = DATA_W'(nos * tos);
      default: aluOut = nos + tos;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      ir <= '0;
      sp <= '0;
    end else begin
      if (ctl.fetch)   pc <= pc + ADDR_W'(1);
      if (ctl.latchIr) ir <= memRdata;
      if (ctl.pushMem)
        sp <= sp + SP_W'(1);
      else if (ctl.popOne || ctl.binop)
        sp <= sp - SP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.pushMem)
      stk[pushIdx] <= memRdata;
    else if (ctl.binop)
      stk[nosIdx] <= aluOut;
  end

  a_r7_sp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(DEPTH));

  a_r7_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pushMem |-> !spFull);

  a_r8_store_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.popOne |-> !spEmpty);

  a_r9_binop_operands: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.binop |-> !spLow);

  a_r9_binop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.binop |=> (sp == $past(sp) - SP_W'(1)));

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] memOp,
  input  logic [OP_W-1:0] irOp,
  input  logic            spFull,
  input  logic            spEmpty,
  input  logic            spLow,
  output ctrl_t           ctl,
  output logic            halted,
  output logic            fault
);

  state_e state, stateNext;
  logic   faultSet;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    faultSet  = 1'b0;
    unique case (state)
      S_FETCH: begin
        ctl.fetch = 1'b1;
        stateNext = S_DECODE;
      end
      S_DECODE: begin
        ctl.latchIr = 1'b1;
        unique case (memOp)
          OP_LOAD: begin
            faultSet  = spFull;
            stateNext = spFull ? S_HALT : S_MEM;
          end
          OP_STORE: begin
            faultSet  = spEmpty;
            stateNext = spEmpty ? S_HALT : S_MEM;
          end
          OP_ADD, OP_SUB, OP_MUL: begin
            faultSet  = spLow;
            stateNext = spLow ? S_HALT : S_EXEC;
          end
          OP_HALT: stateNext = S_HALT;
          default: begin
            faultSet  = 1'b1;
            stateNext = S_HALT;
          end
        endcase
      end
      S_MEM: begin
        if (irOp == OP_STORE) begin
          ctl.dataWrite = 1'b1;
          ctl.popOne    = 1'b1;
          stateNext     = S_FETCH;
        end else begin
          stateNext = S_EXEC;
        end
      end
      S_EXEC: begin
        if (irOp == OP_LOAD) begin
          ctl.pushMem = 1'b1;
        end else begin
          ctl.binop  = 1'b1;
          ctl.aluSel = (irOp == OP_SUB) ? ALU_SUB :
                       (irOp == OP_MUL) ? ALU_MUL : ALU_ADD;
        end
        stateNext = S_FETCH;
      end
      default: stateNext = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      fault <= 1'b0;
    end else begin
      state <= stateNext;
      fault <= fault | faultSet;
    end
  end

  assign halted = (state == S_HALT);

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r10_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !ctl.dataWrite);

  a_r7_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted);

  a_r12_exec_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.pushMem || ctl.binop) |=> (state == S_FETCH));

  a_r3_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.dataWrite |=> !ctl.dataWrite);

endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic [DATA_W-OP_W-1:0]   memAddr,
  output logic                     memWe,
  output logic [DATA_W-1:0]        memWdata,
  input  logic [DATA_W-1:0]        memRdata,
  output logic                     halted,
  output logic                     fault
);

  ctrl_t           ctl;
  logic [OP_W-1:0] irOp;
  logic            spFull, spEmpty, spLow;

  stk_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .memOp   (memRdata[DATA_W-1 -: OP_W]),
    .irOp    (irOp),
    .spFull  (spFull),
    .spEmpty (spEmpty),
    .spLow   (spLow),
    .ctl     (ctl),
    .halted  (halted),
    .fault   (fault)
  );

  stk_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .irOp     (irOp),
    .spFull   (spFull),
    .spEmpty  (spEmpty),
    .spLow    (spLow)
  );

  assign memWe = ctl.dataWrite;

endmodule

// File: tb/sim_stk_core.sv
module sim_stk_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] memAddr;
  logic        memWe;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic        halted;
  logic        fault;

  int errors = 0;
  int checks = 0;

  logic [15:0] mem [4096];

  always #4 clk = ~clk;

  stk_core u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .memAddr  (memAddr),
    .memWe    (memWe),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .halted   (halted),
    .fault    (fault)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
    return {op, a};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic holdReset();
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic runProg(output int cyc);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] vals [8];
    int cyc;
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
             16'h8000, 16'hFFFF, 16'h1234, 16'h00FF};
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;

    // R1: reset state
    holdReset();
    chk(memAddr == 12'h000, "R1 addr", memAddr, 0);
    chk(!memWe && !halted && !fault, "R1 flags", {memWe, halted, fault}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk(memAddr == 12'h000 && !memWe, "R1 first fetch", memAddr, 0);

    // R2/R4/R5/R6/R12: sweep of pairs for each arithmetic opcode
    for (int op = 2; op <= 4; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [15:0] a, b, expv;
          logic [31:0] prod;
          holdReset();
          a = vals[i];
          b = vals[j];
          mem[0] = ins(4'd0, 12'h100);
          mem[1] = ins(4'd0, 12'h101);
          mem[2] = ins(4'(op), 12'h000);
          mem[3] = ins(4'd1, 12'h102);
          mem[4] = ins(4'd15, 12'h000);
          mem[12'h100] = a;
          mem[12'h101] = b;
          mem[12'h102] = 16'hDEAD;
          prod = a * b;
          if (op == 2)      expv = a + b;
          else if (op == 3) expv = a - b;
          else              expv = prod[15:0];
          runProg(cyc);
          if (op == 2)      chk(mem[12'h102] == expv, "R4 add", mem[12'h102], expv);
          else if (op == 3) chk(mem[12'h102] == expv, "R5 sub order", mem[12'h102], expv);
          else              chk(mem[12'h102] == expv, "R6 mul low", mem[12'h102], expv);
          chk(halted && !fault, "R2 decode no fault", {halted, fault}, 2);
          chk(cyc == 16, "R12 cycle count", cyc, 16);
        end
      end
    end

    // R3/R7: fill to depth, drain in reverse
    holdReset();
    for (int k = 0; k < 8; k++) begin
      mem[k]          = ins(4'd0, 12'(12'h200 + k));
      mem[8 + k]      = ins(4'd1, 12'(12'h300 + k));
      mem[12'h200 + k] = 16'(16'h1000 + k * 16'h0111);
      mem[12'h300 + k] = 16'h0000;
    end
    mem[16] = ins(4'd15, 12'h000);
    runProg(cyc);
    chk(halted && !fault, "R7 eight accepted", {halted, fault}, 2);
    for (int k = 0; k < 8; k++)
      chk(mem[12'h300 + k] == 16'(16'h1000 + (7 - k) * 16'h0111), "R3 lifo",
          mem[12'h300 + k], 16'(16'h1000 + (7 - k) * 16'h0111));
    chk(cyc == 8 * 4 + 8 * 3 + 2, "R12 load/store cycles", cyc, 58);

    // R7: ninth load overflows
    holdReset();
    for (int k = 0; k < 9; k++) mem[k] = ins(4'd0, 12'h200);
    mem[9] = ins(4'd1, 12'h3F0);
    mem[12'h3F0] = 16'hCAFE;
    runProg(cyc);
    chk(halted && fault, "R7 overflow fault", {halted, fault}, 3);
    chk(cyc == 34, "R7 stop point", cyc, 34);
    repeat (5) @(negedge clk);
    chk(mem[12'h3F0] == 16'hCAFE, "R7 no write", mem[12'h3F0], 16'hCAFE);

    // R8: store on empty
    holdReset();
    mem[0] = ins(4'd1, 12'h150);
    mem[12'h150] = 16'hBEEF;
    runProg(cyc);
    chk(halted && fault, "R8 underflow fault", {halted, fault}, 3);
    chk(mem[12'h150] == 16'hBEEF, "R8 no write", mem[12'h150], 16'hBEEF);
    chk(cyc == 2, "R12 fault stop", cyc, 2);

    // R9: arithmetic with one word, then with none
    holdReset();
    mem[0] = ins(4'd0, 12'h100);
    mem[1] = ins(4'd2, 12'h000);
    mem[2] = ins(4'd1, 12'h160);
    mem[12'h160] = 16'h5A5A;
    runProg(cyc);
    chk(halted && fault, "R9 one operand", {halted, fault}, 3);
    chk(mem[12'h160] == 16'h5A5A, "R9 no later store", mem[12'h160], 16'h5A5A);
    holdReset();
    mem[0] = ins(4'd3, 12'h000);
    runProg(cyc);
    chk(halted && fault, "R9 empty operands", {halted, fault}, 3);

    // R10: halt stops execution
    holdReset();
    mem[0] = ins(4'd0, 12'h100);
    mem[1] = ins(4'd15, 12'h000);
    mem[2] = ins(4'd1, 12'h170);
    mem[12'h170] = 16'h7777;
    runProg(cyc);
    repeat (10) @(negedge clk);
    chk(halted && !fault, "R10 halt clean", {halted, fault}, 2);
    chk(mem[12'h170] == 16'h7777, "R10 nothing after halt", mem[12'h170], 16'h7777);
    chk(cyc == 6, "R12 halt timing", cyc, 6);

    // R11: undefined opcodes
    for (int op = 5; op <= 14; op++) begin
      holdReset();
      mem[0] = ins(4'(op), 12'h000);
      runProg(cyc);
      chk(halted && fault, "R11 undefined opcode", {halted, fault}, 3);
    end

    // R3/R5/R6: nested expression (A+B)*(C-D)
    holdReset();
    mem[0] = ins(4'd0, 12'h100);
    mem[1] = ins(4'd0, 12'h101);
    mem[2] = ins(4'd2, 12'h000);
    mem[3] = ins(4'd0, 12'h102);
    mem[4] = ins(4'd0, 12'h103);
    mem[5] = ins(4'd3, 12'h000);
    mem[6] = ins(4'd4, 12'h000);
    mem[7] = ins(4'd1, 12'h104);
    mem[8] = ins(4'd15, 12'h000);
    mem[12'h100] = 16'd7;
    mem[12'h101] = 16'd5;
    mem[12'h102] = 16'd3;
    mem[12'h103] = 16'd10;
    runProg(cyc);
    chk(mem[12'h104] == 16'((7 + 5) * (3 - 10)), "R3 nested expression",
        mem[12'h104], 16'((7 + 5) * (3 - 10)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule